// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line and places each received byte into a receive data register. A one-cycle oversampling strobe, normally sixteen times the bit rate, paces the receiver. A frame is one start bit, eight data bits sent least significant bit first, and one or two stop bits. A start is taken only if the line is still low at the middle of the start bit. Each data bit and the first stop bit are sampled at the middle of their bit periods.

Three status flags report the outcome of each frame: receive-full, framing error and overrun. Software reads them through a three-bit status port and clears them through a write strobe. A flag clears only when software has first read it as one and then writes zero to its bit. While either error flag is set, the receiver accepts no new frames. In synchronous mode a pending error also raises a transmit-inhibit output for the neighbouring transmitter. A standby input clears every flag and returns the receiver to idle. The receive data register keeps its contents through standby.

Top module: `srx_async_rx`

## Requirements
- R1: With the receiver enabled and no error pending, a frame whose first stop bit samples high loads its 8 data bits (first bit received into bit 0) into `rx_data` and sets the receive-full flag, status bit 0.
- R2: A low pulse on `rxd` that has ended before the middle of the start bit is not taken as a frame. It changes neither flags nor `rx_data`, and a following valid frame is received normally.
- R3: A frame that completes while receive-full is 1 sets the overrun flag, status bit 2. `rx_data` keeps the earlier byte and the new byte is lost.
- R4: A frame that completes while receive-full is 0 and whose first stop bit samples low sets the framing flag, status bit 1. The byte is loaded into `rx_data` and receive-full stays 0.
- R5: With `two_stop` high, only the first stop bit is checked. A low second stop bit causes no error.
- R6: While the overrun or framing flag is 1, incoming frames change neither `rx_data` nor any flag.
- R7: A write strobe with a 0 in a flag's bit clears that flag only if a status read returned 1 in that bit earlier. A 0 written without such a read leaves the flag set, and a 1 written never clears a flag.
- R8: Synchronous reset clears all flags and `rx_data`. `standby` high clears all flags at the next clock edge.
- R9: With `rx_en` low, no frames are received, and the overrun and framing flags keep their values.
- R10: `tx_inhibit` is 1 exactly when `sync_mode` is 1 and the overrun or framing flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial receive line, idles high |
| rx_en | input | 1 | Receive enable |
| two_stop | input | 1 | Frame has two stop bits |
| sync_mode | input | 1 | Synchronous-mode select, used only for transmit inhibit |
| standby | input | 1 | Clears flags and idles the receiver |
| reg_rd | input | 1 | Status read strobe, arms the clear markers |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 3 | Status write data: bit 0 full, bit 1 framing, bit 2 overrun |
| status_rdata | output | 3 | Flags: bit 0 full, bit 1 framing, bit 2 overrun |
| rx_data | output | 8 | Receive data register |
| tx_inhibit | output | 1 | Transmit inhibit for synchronous mode |

## Verification
The assertions check four rules on every cycle. Transmit inhibit must follow the error flags and sync mode. `rx_data` must not move while an error is pending or when overrun rises. The framing flag must not fall except through a zero write or standby, and standby must leave all flags clear. Only the directed scenarios can show that bits land in the right order, that a short glitch is rejected, and that a low second stop bit is ignored. The same holds for the read-before-write rule and for the choice between overrun and framing error, because these depend on whole frames and on sequences of register accesses.

// File: rtl/srx_pkg.sv
// Shared types for the asynchronous receiver.
// Assumes: status bit positions are fixed because software decodes them.
package srx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;

    localparam int unsigned FLG_FULL = 0;
    localparam int unsigned FLG_FRM  = 1;
    localparam int unsigned FLG_OVR  = 2;
    localparam int unsigned NFLAGS   = 3;
endpackage

// File: rtl/srx_frame_engine.sv
// Frame engine: detects a start bit, samples data bits at mid-bit, checks the
// first stop bit and emits a one-cycle completion event.
// Assumes: tick pulses OSR times per bit; rxd is already synchronised.
module srx_frame_engine
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              blocked,
    input  logic              two_stop,
    output logic              evt_valid,
    output logic              evt_stop_ok,
    output logic [DATA_W-1:0] evt_data
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned IW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
    localparam logic [IW-1:0] LAST_BIT = IW'(DATA_W - 1);

    rx_state_t         st;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     nbit;
    logic [DATA_W-1:0] shreg;

    assign evt_data = shreg;

    // Sequencer: walks start, data and stop phases on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            st          <= RX_IDLE;
            cnt         <= '0;
            nbit        <= '0;
            shreg       <= '0;
            evt_valid   <= 1'b0;
            evt_stop_ok <= 1'b0;
        end else begin
            evt_valid <= 1'b0;
            if (!rx_en) begin
                st <= RX_IDLE;
            end else if (tick) begin
                case (st)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!blocked && !rxd) st <= RX_START;
                    end
                    RX_START: begin
                        if (cnt == MID_CNT) begin
                            cnt  <= '0;
                            nbit <= '0;
                            st   <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            shreg <= {rxd, shreg[DATA_W-1:1]};
                            nbit  <= nbit + IW'(1);
                            if (nbit == LAST_BIT) st <= RX_STOP1;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    RX_STOP1: begin
                        if (cnt == LAST_CNT) begin
                            cnt         <= '0;
                            evt_valid   <= 1'b1;
                            evt_stop_ok <= rxd;
                            st          <= two_stop ? RX_STOP2 : RX_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    RX_STOP2: begin
                        if (cnt == LAST_CNT) st <= RX_IDLE;
                        else                 cnt <= cnt + CW'(1);
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_flag_bank.sv
// Sticky flag bank: each flag sets on its event and clears only after a read
// that returned 1 for it, followed by a write of 0 to its bit.
// Assumes: set wins over a clear in the same cycle; standby clears everything.
module srx_flag_bank #(
    parameter int unsigned NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic [NF-1:0] set_vec,
    input  logic          rd,
    input  logic          wr,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] armed;

    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
        // One flag cell with its read-as-one marker.
        always_ff @(posedge clk) begin
            if (!rst_n || standby) begin
                flags[gi] <= 1'b0;
                armed[gi] <= 1'b0;
            end else if (set_vec[gi]) begin
                flags[gi] <= 1'b1;
            end else begin
                if (rd && flags[gi]) armed[gi] <= 1'b1;
                if (wr && !wdata[gi] && armed[gi]) begin
                    flags[gi] <= 1'b0;
                    armed[gi] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/srx_async_rx.sv
// Receiver top: joins the frame engine to the flag bank and holds the
// receive data register. Decides between load, overrun and framing error.
// Assumes: one completion event per frame; status bit 0 full, 1 framing, 2 overrun.
module srx_async_rx
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              two_stop,
    input  logic              sync_mode,
    input  logic              standby,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [2:0]        reg_wdata,
    output logic [2:0]        status_rdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_inhibit
);
    logic              evt_valid;
    logic              evt_stop_ok;
    logic [DATA_W-1:0] evt_data;
    logic [NFLAGS-1:0] flags;
    logic [NFLAGS-1:0] set_vec;
    logic              err_pending;
    logic              load_data;

    assign err_pending = flags[FLG_OVR] | flags[FLG_FRM];

    srx_frame_engine #(.DATA_W(DATA_W), .OSR(OSR)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby     (standby),
        .tick        (os_tick),
        .rxd         (rxd),
        .rx_en       (rx_en),
        .blocked     (err_pending),
        .two_stop    (two_stop),
        .evt_valid   (evt_valid),
        .evt_stop_ok (evt_stop_ok),
        .evt_data    (evt_data)
    );

    // Outcome of a completed frame: overrun has priority over framing error.
    always_comb begin
        set_vec          = '0;
        set_vec[FLG_OVR] = evt_valid && flags[FLG_FULL];
        set_vec[FLG_FULL] = evt_valid && !flags[FLG_FULL] && evt_stop_ok;
        set_vec[FLG_FRM] = evt_valid && !flags[FLG_FULL] && !evt_stop_ok;
        load_data        = set_vec[FLG_FULL] || set_vec[FLG_FRM];
    end

    srx_flag_bank #(.NF(NFLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .set_vec (set_vec),
        .rd      (reg_rd),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .flags   (flags)
    );

    // Receive data register: written only when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_data <= '0;
        else if (load_data) rx_data <= evt_data;
    end

    assign status_rdata = flags;
    assign tx_inhibit   = sync_mode & err_pending;
endmodule

// File: rtl/srx_async_rx_chk.sv
// Checker for the receiver top, attached by bind. Watches only ports.
module srx_async_rx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              sync_mode,
    input logic              reg_wr,
    input logic [2:0]        reg_wdata,
    input logic [2:0]        status_rdata,
    input logic [DATA_W-1:0] rx_data,
    input logic              tx_inhibit
);
    AST_TX_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit == (sync_mode && (status_rdata[2] || status_rdata[1]))); // R10
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_rdata[2]) |-> $stable(rx_data)); // R3
    AST_BLOCKED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rdata[2] || status_rdata[1]) |=> $stable(rx_data)); // R6
    AST_FRM_CLEAR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_rdata[1]) |-> ($past(standby) || ($past(reg_wr) && !$past(reg_wdata[1])))); // R7
    AST_STANDBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (status_rdata == 3'b000)); // R8
endmodule

bind srx_async_rx srx_async_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby      (standby),
    .sync_mode    (sync_mode),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .status_rdata (status_rdata),
    .rx_data      (rx_data),
    .tx_inhibit   (tx_inhibit)
);

// File: tb/srx_async_rx_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module srx_async_rx_tb;
    localparam int CLK_P = 10;
    localparam int OSR   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic       two_stop = 1'b0;
    logic       sync_mode = 1'b0;
    logic       standby = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_wdata = 3'b111;
    logic [2:0] status_rdata;
    logic [7:0] rx_data;
    logic       tx_inhibit;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    srx_async_rx u_dut (
        .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .rxd (rxd),
        .rx_en (rx_en), .two_stop (two_stop), .sync_mode (sync_mode),
        .standby (standby), .reg_rd (reg_rd), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .status_rdata (status_rdata),
        .rx_data (rx_data), .tx_inhibit (tx_inhibit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        idle(OSR);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic s1, input logic s2);
        @(negedge clk);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(s1);
        if (two_stop) send_bit(s2);
        rxd = 1'b1;
        idle(30);
    endtask

    // Read status then write: bits set in clr_mask get 0, others 1.
    task automatic clear_flags(input logic [2:0] clr_mask);
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; reg_wr = 1'b1; reg_wdata = ~clr_mask;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = 3'b111;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(status_rdata == 3'b000, "R8 reset status", status_rdata, 0);
        chk(rx_data == 8'h00, "R8 reset data", rx_data, 0);
        chk(tx_inhibit == 1'b0, "R10 reset inhibit", tx_inhibit, 0);
    endtask

    task automatic t_basic;
        send_frame(8'hA5, 1'b1, 1'b1);
        chk(rx_data == 8'hA5, "R1 data", rx_data, 8'hA5);
        chk(status_rdata == 3'b001, "R1 full", status_rdata, 1);
        clear_flags(3'b001);
        chk(status_rdata == 3'b000, "R7 read-write clears full", status_rdata, 0);
    endtask

    task automatic t_write_no_read;
        send_frame(8'h3C, 1'b1, 1'b1);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 3'b000;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = 3'b111;
        @(negedge clk);
        chk(status_rdata == 3'b001, "R7 write without read", status_rdata, 1);
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; reg_wr = 1'b1; reg_wdata = 3'b111;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk);
        chk(status_rdata == 3'b001, "R7 write one keeps", status_rdata, 1);
        clear_flags(3'b001);
        chk(status_rdata == 3'b000, "R7 cleared", status_rdata, 0);
    endtask

    task automatic t_false_start;
        @(negedge clk); rxd = 1'b0;
        idle(4);
        rxd = 1'b1;
        idle(60);
        chk(status_rdata == 3'b000, "R2 glitch no flag", status_rdata, 0);
        chk(rx_data == 8'h3C, "R2 glitch no data", rx_data, 8'h3C);
        send_frame(8'h81, 1'b1, 1'b1);
        chk(rx_data == 8'h81, "R2 next frame", rx_data, 8'h81);
        clear_flags(3'b001);
    endtask

    task automatic t_overrun;
        send_frame(8'h11, 1'b1, 1'b1);
        send_frame(8'h22, 1'b1, 1'b1);
        chk(status_rdata == 3'b101, "R3 overrun flag", status_rdata, 5);
        chk(rx_data == 8'h11, "R3 old data kept", rx_data, 8'h11);
        chk(tx_inhibit == 1'b0, "R10 async no inhibit", tx_inhibit, 0);
        sync_mode = 1'b1; @(negedge clk);
        chk(tx_inhibit == 1'b1, "R10 sync inhibit", tx_inhibit, 1);
        sync_mode = 1'b0;
        send_frame(8'h33, 1'b1, 1'b1);
        chk(rx_data == 8'h11, "R6 blocked by overrun", rx_data, 8'h11);
        chk(status_rdata == 3'b101, "R6 flags unchanged", status_rdata, 5);
        clear_flags(3'b100);
        chk(status_rdata == 3'b001, "R7 clear overrun only", status_rdata, 1);
        clear_flags(3'b001);
    endtask

    task automatic t_framing;
        send_frame(8'h5A, 1'b0, 1'b1);
        chk(rx_data == 8'h5A, "R4 data loaded", rx_data, 8'h5A);
        chk(status_rdata == 3'b010, "R4 framing no full", status_rdata, 2);
        send_frame(8'h77, 1'b1, 1'b1);
        chk(rx_data == 8'h5A, "R6 blocked by framing", rx_data, 8'h5A);
        rx_en = 1'b0; idle(3);
        chk(status_rdata == 3'b010, "R9 disable keeps flag", status_rdata, 2);
        rx_en = 1'b1;
        sync_mode = 1'b1; @(negedge clk);
        chk(tx_inhibit == 1'b1, "R10 framing inhibit", tx_inhibit, 1);
        sync_mode = 1'b0;
        clear_flags(3'b010);
        chk(status_rdata == 3'b000, "R7 framing cleared", status_rdata, 0);
    endtask

    task automatic t_two_stop;
        two_stop = 1'b1;
        send_frame(8'hC3, 1'b1, 1'b0);
        chk(status_rdata == 3'b001, "R5 second stop ignored", status_rdata, 1);
        chk(rx_data == 8'hC3, "R5 data", rx_data, 8'hC3);
        clear_flags(3'b001);
        send_frame(8'h0F, 1'b0, 1'b1);
        chk(status_rdata == 3'b010, "R5 first stop checked", status_rdata, 2);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
        chk(status_rdata == 3'b000, "R8 standby clears", status_rdata, 0);
        two_stop = 1'b0;
    endtask

    task automatic t_disabled;
        rx_en = 1'b0;
        send_frame(8'h99, 1'b1, 1'b1);
        chk(status_rdata == 3'b000, "R9 disabled no flag", status_rdata, 0);
        chk(rx_data == 8'h0F, "R9 disabled no data", rx_data, 8'h0F);
        rx_en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_basic();
        t_write_no_read();
        t_false_start();
        t_overrun();
        t_framing();
        t_two_stop();
        t_disabled();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule